// File: doc/BRIEF.md
# Dual-Role Power-Down Sequencer

This block manages a single asynchronous control pin that has two roles. After reset the pin acts as a power-good qualifier, and the block keeps every clock output gated low and the oscillators disabled. Once the pin has been seen high, its role changes. From then on it is an active-low power-down request, and releasing it starts a power-up.

The block produces its own divided clock outputs. Output `i` has a half period of `HALF_BASE*(i+1)` reference cycles. A differential pair follows output 0.

On a power-down request, each output finishes its current high phase in full and is then held low. The oscillator enable is dropped only after every output is low and gated. Release runs the steps in reverse:

1. The oscillators are enabled again.
2. The block waits a programmable lock count.
3. Each output is ungated at the start of a low phase.

Top module: `pdn_seq_top`

## Requirements
- R1: After reset the status is 0 (waiting for power-good), `osc_en` is 0, and all clock outputs and both differential lines are 0. The status codes are: 0 waiting, 1 running, 2 stopping, 3 powered down, 4 restarting.
- R2: While waiting for power-good, a low pin is not treated as a power-down request. Nothing is enabled until the pin is high on two consecutive synchronized samples.
- R3: The pin passes through a two-flop synchronizer. A level is acted on only when two consecutive synchronized samples agree, so a low pulse lasting one reference cycle leaves a running block running.
- R4: When a power-down request is recognized while running, the status becomes 2. No output high phase is ever cut short: every high phase of output `i` lasts exactly `HALF_BASE*(i+1)` cycles. After its next falling edge, the output stays low.
- R5: `osc_en` stays 1 until every output is low and gated. The status then becomes 3 and `osc_en` becomes 0. Whenever `osc_en` is 0, all outputs and both differential lines are 0.
- R6: A release recognized in status 3 moves the status to 4 with `osc_en` at 1 and the outputs low. The status stays 4 for exactly `lock_count+1` cycles and then becomes 1.
- R7: While running, output `i` toggles with a half period of `HALF_BASE*(i+1)` cycles. It always starts with a full low phase after ungating.
- R8: `dif_p` equals output 0. `dif_n` is its complement while output 0 is ungated, and 0 while it is gated.
- R9: A power-down request recognized while restarting goes to status 2 and then 3 without ungating any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_pin | input | 1 | Asynchronous dual-role pin: power-good first, then active-low power-down |
| lock_count | input | LOCK_W | Cycles to wait for oscillator lock, minus one |
| clk_out | output | N_OUT | Gated divided clock outputs |
| dif_p | output | 1 | Differential true line (follows output 0) |
| dif_n | output | 1 | Differential complement line, low when gated |
| osc_en | output | 1 | Oscillator and crystal enable |
| status | output | 3 | Sequencer state code |

## Verification
The assertions assume that `lock_count` is held stable while the block is restarting. They also assume that reset is only applied as a whole-block event. The bench changes `lock_count` only while the block is waiting or powered down.

The bench drives the pin on the falling clock edge, so the synchronizer always sees a clean level. Single-cycle pulses are made exactly one reference period long, which keeps them inside the case the two-sample filter is meant to reject.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_PG = 3'd0,
    ST_RUN     = 3'd1,
    ST_STOP    = 3'd2,
    ST_DOWN    = 3'd3,
    ST_RESTART = 3'd4
  } pdn_state_t;
endpackage

// File: rtl/pdn_sync.sv
module pdn_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic both_hi,
  output logic both_lo
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign both_hi = sync_q & prev_q;
  assign both_lo = ~sync_q & ~prev_q;
endmodule

// File: rtl/pdn_clkgate.sv
module pdn_clkgate #(
  parameter int HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic clk_o,
  output logic live
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic q_q, q_d, act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    q_d   = q_q;
    act_d = act_q;
    if (!act_q) begin
      cnt_d = '0;
      q_d   = 1'b0;
      act_d = run;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      if (q_q && !run) begin
        q_d   = 1'b0;
        act_d = 1'b0;
      end else begin
        q_d = ~q_q;
      end
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
      act_q <= act_d;
    end
  end

  assign clk_o = q_q;
  assign live  = act_q;

  AST_GATE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_q) |-> ($past(q_q) && !q_q)); // R4
  AST_UNGATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> !q_q); // R7
endmodule

// File: rtl/pdn_fsm.sv
module pdn_fsm
  import pdn_pkg::*;
#(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_hi,
  input  logic              pin_lo,
  input  logic              all_off,
  input  logic [LOCK_W-1:0] lock_count,
  output logic              run,
  output logic              osc_en,
  output pdn_state_t        state
);
  pdn_state_t st_q, st_d;
  logic [LOCK_W-1:0] lk_q, lk_d;

  always_comb begin
    st_d = st_q;
    lk_d = lk_q;
    case (st_q)
      ST_WAIT_PG: if (pin_hi) begin st_d = ST_RESTART; lk_d = '0; end
      ST_RESTART: begin
        if (pin_lo)                  st_d = ST_STOP;
        else if (lk_q == lock_count) st_d = ST_RUN;
        else                         lk_d = lk_q + LOCK_W'(1);
      end
      ST_RUN:     if (pin_lo)  st_d = ST_STOP;
      ST_STOP:    if (all_off) st_d = ST_DOWN;
      ST_DOWN:    if (pin_hi) begin st_d = ST_RESTART; lk_d = '0; end
      default:    st_d = ST_WAIT_PG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_WAIT_PG;
      lk_q <= '0;
    end else begin
      st_q <= st_d;
      lk_q <= lk_d;
    end
  end

  assign state  = st_q;
  assign run    = (st_q == ST_RUN);
  assign osc_en = (st_q == ST_RESTART) || (st_q == ST_RUN) || (st_q == ST_STOP);

  AST_STOP_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && pin_lo) |=> (st_q == ST_STOP)); // R4
  AST_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && $past(st_q) == ST_RESTART) |-> ($past(lk_q) == lock_count)); // R6
  AST_DOWN_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DOWN && $past(st_q) == ST_STOP) |-> $past(all_off)); // R5
endmodule

// File: rtl/pdn_seq_top.sv
module pdn_seq_top
  import pdn_pkg::*;
#(
  parameter int N_OUT     = 3,
  parameter int HALF_BASE = 1,
  parameter int LOCK_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_pin,
  input  logic [LOCK_W-1:0] lock_count,
  output logic [N_OUT-1:0]  clk_out,
  output logic              dif_p,
  output logic              dif_n,
  output logic              osc_en,
  output logic [2:0]        status
);
  logic pin_hi, pin_lo, run;
  logic [N_OUT-1:0] live;
  pdn_state_t state;

  pdn_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(pwr_pin),
    .both_hi(pin_hi), .both_lo(pin_lo)
  );

  pdn_fsm #(.LOCK_W(LOCK_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pin_hi(pin_hi), .pin_lo(pin_lo),
    .all_off(~|live), .lock_count(lock_count),
    .run(run), .osc_en(osc_en), .state(state)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    pdn_clkgate #(.HALF(HALF_BASE * (i + 1))) u_gate (
      .clk(clk), .rst_n(rst_n), .run(run),
      .clk_o(clk_out[i]), .live(live[i])
    );
  end

  assign dif_p  = clk_out[0];
  assign dif_n  = live[0] & ~clk_out[0];
  assign status = state;

  AST_QUIET_BEFORE_PG: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd0) |-> (clk_out == '0 && !osc_en)); // R2
  AST_OSC_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (clk_out == '0 && !dif_p && !dif_n)); // R5
  AST_RESTART_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 3'd4) |-> (clk_out == '0)); // R9
endmodule

// File: tb/sim_pdn_seq_top.sv
module sim_pdn_seq_top;
  localparam int N = 3;
  localparam int LW = 8;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_pin = 1'b0;
  logic [LW-1:0] lock_count = 8'd3;
  logic [N-1:0] clk_out;
  logic dif_p, dif_n, osc_en;
  logic [2:0] status;
  int total = 0;
  int bad = 0;
  int hi_len [N];

  always #5 clk = ~clk;

  pdn_seq_top #(.N_OUT(N), .HALF_BASE(1), .LOCK_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_pin(pwr_pin), .lock_count(lock_count),
    .clk_out(clk_out), .dif_p(dif_p), .dif_n(dif_n), .osc_en(osc_en), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_status(input int val, input int maxc, output int took);
    took = 0;
    while (status != 3'(val) && took < maxc) begin
      @(negedge clk);
      took++;
    end
  endtask

  // R4 R7: every high phase keeps its full length; R5: osc off implies quiet outputs
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (clk_out[i]) hi_len[i]++;
        else begin
          if (hi_len[i] != 0) chk(hi_len[i] == i + 1, "R4 high phase", hi_len[i], i + 1);
          hi_len[i] = 0;
        end
      end
      if (!osc_en && (clk_out != '0 || dif_p || dif_n))
        chk(1'b0, "R5 quiet when osc off", int'(clk_out), 0);
    end else begin
      for (int i = 0; i < N; i++) hi_len[i] = 0;
    end
  end

  task automatic t_reset;
    @(negedge clk);
    chk(status == 3'd0, "R1 status", status, 0);
    chk(osc_en == 1'b0, "R1 osc_en", osc_en, 0);
    chk(clk_out == '0 && !dif_p && !dif_n, "R1 outputs", int'(clk_out), 0);
  endtask

  task automatic t_wait_pg;
    repeat (10) @(negedge clk);
    chk(status == 3'd0, "R2 low pin while waiting", status, 0);
    pwr_pin = 1'b1;
    @(negedge clk);
    pwr_pin = 1'b0;
    repeat (10) @(negedge clk);
    chk(status == 3'd0, "R3 single high sample ignored", status, 0);
    chk(osc_en == 1'b0, "R2 osc stays off", osc_en, 0);
  endtask

  task automatic t_power_up(input int lk);
    int took;
    int cyc;
    lock_count = LW'(lk);
    pwr_pin = 1'b1;
    wait_status(4, 20, took);
    chk(status == 3'd4, "R6 enters restart", status, 4);
    chk(osc_en == 1'b1, "R6 osc on in restart", osc_en, 1);
    cyc = 0;
    while (status == 3'd4 && cyc < 300) begin
      chk(clk_out == '0, "R6 outputs gated in restart", int'(clk_out), 0);
      @(negedge clk);
      cyc++;
    end
    chk(cyc == lk + 1, "R6 lock cycles", cyc, lk + 1);
    chk(status == 3'd1, "R6 running", status, 1);
  endtask

  task automatic t_toggle;
    int seen_hi [N];
    for (int i = 0; i < N; i++) seen_hi[i] = 0;
    chk(clk_out == '0, "R7 starts low", int'(clk_out), 0);
    repeat (24) begin
      @(negedge clk);
      for (int i = 0; i < N; i++) if (clk_out[i]) seen_hi[i]++;
    end
    for (int i = 0; i < N; i++)
      chk(seen_hi[i] == 12, "R7 duty", seen_hi[i], 12);
  endtask

  task automatic t_glitch;
    pwr_pin = 1'b0;
    @(negedge clk);
    pwr_pin = 1'b1;
    repeat (12) @(negedge clk);
    chk(status == 3'd1, "R3 one-cycle low ignored", status, 1);
  endtask

  task automatic t_diff;
    int ok = 1;
    repeat (12) begin
      @(negedge clk);
      if (dif_p != clk_out[0] || dif_n != ~clk_out[0]) ok = 0;
    end
    chk(ok == 1, "R8 differential pair", ok, 1);
  endtask

  task automatic t_power_down;
    int took;
    pwr_pin = 1'b0;
    wait_status(2, 10, took);
    chk(status == 3'd2, "R4 stopping", status, 2);
    wait_status(3, 30, took);
    chk(status == 3'd3, "R5 powered down", status, 3);
    chk(osc_en == 1'b0, "R5 osc off", osc_en, 0);
    chk(clk_out == '0 && !dif_p && !dif_n, "R8 gated pair low", int'({dif_p, dif_n}), 0);
    repeat (15) @(negedge clk);
    chk(status == 3'd3 && clk_out == '0, "R5 stays down", status, 3);
  endtask

  task automatic t_pd_in_restart;
    int took;
    int lit = 0;
    lock_count = 8'd40;
    pwr_pin = 1'b1;
    wait_status(4, 20, took);
    repeat (3) @(negedge clk);
    pwr_pin = 1'b0;
    took = 0;
    while (status != 3'd3 && took < 30) begin
      @(negedge clk);
      took++;
      if (clk_out != '0) lit = 1;
    end
    chk(status == 3'd3, "R9 down from restart", status, 3);
    chk(lit == 0, "R9 never ungated", lit, 0);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wait_pg();
    t_power_up(3);
    t_toggle();
    t_glitch();
    t_diff();
    t_power_down();
    t_power_up(7);
    t_toggle();
    t_power_down();
    t_pd_in_restart();
    t_power_up(0);
    t_diff();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule